// File: doc/BRIEF.md
# Truncated Rounding Fractional Multiplier

This block multiplies two unsigned N-bit fractions and returns an N-bit product that is already rounded. Operand bit i weighs 2^(i-N), and bit c of the double-width product weighs 2^(c-2N). The block never builds the low part of the partial-product matrix. It forms only the partial-product bits whose column index c is T = N-K or higher, so N+K columns are kept. It then adds a correction value in place of the dropped columns and the rounding step. The output is bits N through 2N-1 of that sum.

A compile-time mode picks one of two corrections. In the data-dependent variable mode, every partial-product bit of column T-1 is added at the weight of column T, together with a small rounding constant. In the fixed constant mode, a single constant derived from the expected error is added and no operand-dependent term is used.

Operands enter on a valid/ready stream and the product leaves on another one. When the output register is enabled, an accepted pair appears one cycle later and waits in place while the consumer stalls. Input back-pressure follows the rule `in_ready = !out_valid || out_ready`. When the register is disabled, the stage is a wire, with valid passed forward and ready passed back in the same cycle.

Top module: `tmul_round_mul`

## Requirements
- R1: `p` equals bits N..2N-1 of S, where S is the sum of all a_i·b_j terms with i+j >= T placed at bit i+j, plus the mode's correction (units of 2^-2N). S never reaches 2^2N.
- R2: In variable mode, each term a_i·b_j with i+j = T-1 adds 2^T to S. Terms with i+j < T-1 add nothing.
- R3: In variable mode the rounding constant is 2^(N-1) - 2^(N-K) units, which is 64 for N=8, K=2.
- R4: In constant mode the constant is round(S4 / 2^(T+2)) · 2^T units, where S4 = Σ_{i<T}(i+1)·2^i + 2^(N+1) - 2^(N+1-K). This is 160 for N=8, K=3.
- R5: For the default sizes, |p·2^N - A·B| <= 2^N, with A and B as integers.
- R6: Zero operands give a zero product in both modes.
- R7: With the output register on, a pair accepted on an edge drives `out_valid`=1 and its product from that edge on. While `out_valid`=1 and `out_ready`=0, `p` and `out_valid` hold.
- R8: With the register on, `in_ready` = !out_valid || out_ready. With it off, `out_valid` follows `in_valid` and `in_ready` follows `out_ready` combinationally.
- R9: A synchronous active-high `rst` clears `out_valid` and `p` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when the output register is on) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block accepts the pair this cycle |
| a | input | N | Multiplicand fraction |
| b | input | N | Multiplier fraction |
| out_valid | output | 1 | Product is present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| p | output | N | Rounded truncated product |

## Verification
All 65536 operand pairs are swept through a variable-mode instance (N=8, K=2, registered) and a constant-mode instance (N=8, K=3, combinational). Each pair is compared with the column-sum definition and with the one-ulp error bound. A design that folded column T-1 at the wrong weight, mis-placed a constant bit, or kept one column too many or too few would miss on many pairs, while all-ones operands expose any carry lost at the top. The stall case holds a product while new operands wait, which catches a register that overwrites its output under back-pressure or a ready that ignores the full stage. The reset case checks that no stale valid survives reset.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

  typedef enum logic {
    CORR_VARIABLE = 1'b0,
    CORR_CONSTANT = 1'b1
  } corr_mode_e;

  // Correction in units of 2^-(2n) for width n, kept extra columns k.
  function automatic longint unsigned corr_units(input int n, input int k,
                                                 input corr_mode_e m);
    longint unsigned s4;
    longint unsigned q;
    int t;
    t = n - k;
    if (m == CORR_VARIABLE) begin
      return (64'd1 << (n - 1)) - (64'd1 << (n - k));
    end
    s4 = 64'd0;
    for (int i = 0; i < t; i++) begin
      s4 += longint'(i + 1) << i;
    end
    s4 += (64'd1 << (n + 1)) - (64'd1 << (n + 1 - k));
    q = (s4 + (64'd1 << (t + 1))) >> (t + 2);
    return q << t;
  endfunction

endpackage

// File: rtl/tmul_pp_rows.sv
module tmul_pp_rows #(
  parameter int N = 8,
  parameter int T = 6,
  parameter tmul_pkg::corr_mode_e MODE = tmul_pkg::CORR_VARIABLE,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [W-1:0] rows [N],
  output logic [W-1:0] fold
);
  localparam logic [W-1:0] KEEP_MASK = {W{1'b1}} << T;

  // One shifted partial-product row per multiplier bit, low columns cleared.
  for (genvar j = 0; j < N; j++) begin : g_row
    assign rows[j] = ({{N{1'b0}}, a & {N{b[j]}}} << j) & KEEP_MASK;
  end

  if (MODE == tmul_pkg::CORR_VARIABLE) begin : g_fold
    logic [W-1:0] cnt;
    // Bits of column T-1 each count once at the weight of column T.
    always_comb begin
      cnt = '0;
      for (int i = 0; i < T; i++) begin
        cnt = cnt + W'(a[i] & b[T-1-i]);
      end
    end
    assign fold = cnt << T;
  end else begin : g_nofold
    assign fold = '0;
  end

endmodule

// File: rtl/tmul_accum.sv
module tmul_accum #(
  parameter int N = 8,
  localparam int W = 2 * N,
  parameter logic [W:0] CORR = '0
) (
  input  logic [W-1:0] rows [N],
  input  logic [W-1:0] fold,
  output logic [W:0]   sum
);
  always_comb begin
    sum = CORR + {1'b0, fold};
    for (int j = 0; j < N; j++) begin
      sum = sum + {1'b0, rows[j]};
    end
    // R1
    no_overflow_chk: assert (sum[W] == 1'b0)
      else $error("truncated sum carried past the top column");
  end

endmodule

// File: rtl/tmul_outstage.sv
module tmul_outstage #(
  parameter int N = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] q
);
  if (REG_OUT) begin : g_reg
    logic         vld_r;
    logic [N-1:0] q_r;
    logic         load;

    assign in_ready  = !vld_r || out_ready;
    assign load      = in_valid && in_ready;
    assign out_valid = vld_r;
    assign q         = q_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r <= 1'b0;
        q_r   <= '0;
      end else if (load) begin
        vld_r <= 1'b1;
        q_r   <= d;
      end else if (out_ready) begin
        vld_r <= 1'b0;
      end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(q)));
    // R7
    accept_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && q == '0));
  end else begin : g_pass
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign q         = d;
  end

endmodule

// File: rtl/tmul_round_mul.sv
module tmul_round_mul #(
  parameter int N = 8,
  parameter int K = 2,
  parameter tmul_pkg::corr_mode_e MODE = tmul_pkg::CORR_VARIABLE,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] p
);
  localparam int T = N - K;
  localparam int W = 2 * N;
  localparam logic [W:0] CORR = (W+1)'(tmul_pkg::corr_units(N, K, MODE));

  logic [W-1:0] rows [N];
  logic [W-1:0] fold;
  logic [W:0]   sum;
  logic [N-1:0] p_comb;

  tmul_pp_rows #(.N(N), .T(T), .MODE(MODE)) rows_i (
    .a(a), .b(b), .rows(rows), .fold(fold)
  );

  tmul_accum #(.N(N), .CORR(CORR)) accum_i (
    .rows(rows), .fold(fold), .sum(sum)
  );

  assign p_comb = sum[W-1:N];

  tmul_outstage #(.N(N), .REG_OUT(REG_OUT)) out_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .d(p_comb),
    .out_valid(out_valid), .out_ready(out_ready), .q(p)
  );

  logic [W-1:0] exact;
  logic [W-1:0] est;
  logic [W-1:0] err;
  always_comb begin
    exact = W'(a) * W'(b);
    est   = {p_comb, {N{1'b0}}};
    err   = (est > exact) ? (est - exact) : (exact - est);
    // R5
    err_bound_chk: assert (err <= (W'(1) << N))
      else $error("truncated product is more than one ulp away");
    // R6
    zero_in_chk: assert (!(a == '0 && b == '0) || p_comb == '0)
      else $error("zero operands gave a nonzero product");
  end

endmodule

// File: tb/tmul_round_mul_tb.sv
module tmul_round_mul_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic in_ready_v, out_valid_v, in_ready_c, out_valid_c;
  logic [7:0] p_v, p_c;
  int ntests = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  tmul_round_mul #(.N(8), .K(2), .MODE(tmul_pkg::CORR_VARIABLE), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_v),
    .a(a), .b(b), .out_valid(out_valid_v), .out_ready(out_ready), .p(p_v)
  );

  tmul_round_mul #(.N(8), .K(3), .MODE(tmul_pkg::CORR_CONSTANT), .REG_OUT(1'b0)) dut_c_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_c),
    .a(a), .b(b), .out_valid(out_valid_c), .out_ready(out_ready), .p(p_c)
  );

  task automatic chk(input string tag, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Column-sum definition: R1 kept columns, R2 fold of column T-1.
  function automatic int ref_p(input int av, input int bv, input int k,
                               input bit cmode, input int corr);
    int t = 8 - k;
    int s = corr;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (av[i] && bv[j]) begin
          if (i + j >= t) s += 1 << (i + j);
          else if (!cmode && (i + j == t - 1)) s += 1 << t;
        end
    return (s >> 8) & 255;
  endfunction

  function automatic int err_ok(input int pv, input int av, input int bv);
    int d = pv * 256 - av * bv;
    if (d < 0) d = -d;
    return (d <= 256) ? 1 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int pa, pb, s4, q;
    // R3 / R4: constant values from their formulas
    chk("R3 variable constant", (1 << 7) - (1 << 6), 64);
    s4 = 0;
    for (int i = 0; i < 5; i++) s4 += (i + 1) << i;
    s4 += (1 << 9) - (1 << 6);
    q = (s4 + (1 << 6)) >> 7;
    chk("R4 constant value", q << 5, 160);

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid in reset", int'(out_valid_v), 0);
    chk("R9 p in reset", int'(p_v), 0);
    rst = 1'b0;

    // R8 / R7 back-pressure
    out_ready = 1'b0; in_valid = 1'b1; a = 8'd200; b = 8'd100;
    #1 chk("R8 ready while empty", int'(in_ready_v), 1);
    @(negedge clk);
    chk("R7 valid after accept", int'(out_valid_v), 1);
    chk("R7 product after accept", int'(p_v), ref_p(200, 100, 2, 1'b0, 64));
    chk("R8 ready low when full and stalled", int'(in_ready_v), 0);
    a = 8'd1; b = 8'd1;
    @(negedge clk);
    chk("R7 hold valid under stall", int'(out_valid_v), 1);
    chk("R7 hold product under stall", int'(p_v), ref_p(200, 100, 2, 1'b0, 64));
    out_ready = 1'b1;
    #1 chk("R8 ready when consumer takes", int'(in_ready_v), 1);
    chk("R8 pass-through valid", int'(out_valid_c), 1);
    in_valid = 1'b0;
    #1 chk("R8 pass-through valid low", int'(out_valid_c), 0);
    out_ready = 1'b0;
    #1 chk("R8 pass-through ready", int'(in_ready_c), 0);
    out_ready = 1'b1; in_valid = 1'b1;
    pa = 1; pb = 1;

    // Exhaustive sweep, both modes
    for (int x = 0; x < 65536; x++) begin
      @(negedge clk);
      chk("R1 R2 R3 variable product", int'(p_v), ref_p(pa, pb, 2, 1'b0, 64));
      chk("R5 variable error bound", err_ok(int'(p_v), pa, pb), 1);
      a = 8'(x >> 8); b = 8'(x);
      pa = x >> 8; pb = x & 255;
      #1;
      chk("R1 R4 constant product", int'(p_c), ref_p(pa, pb, 3, 1'b1, 160));
      chk("R5 constant error bound", err_ok(int'(p_c), pa, pb), 1);
      if (x == 0) chk("R6 zero operands constant mode", int'(p_c), 0);
      if (x == 1) chk("R6 zero operands variable mode", int'(p_v), 0);
    end
    @(negedge clk);
    chk("R1 variable all ones", int'(p_v), ref_p(255, 255, 2, 1'b0, 64));

    // R9 reset clears a full stage
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset clears valid", int'(out_valid_v), 0);
    chk("R9 reset clears product", int'(p_v), 0);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule